// File: doc/BRIEF.md
# Synchronous serial slave receiver

This block receives words from a serial link whose shift clock is driven by an outside master. It brings the serial clock and data lines into the system clock domain, finds each falling edge of the serial clock, and shifts the data bit in, least significant bit first. A word is eight bits long, or nine when the long-word mode is selected. When a word is complete, the low eight bits go to a data register, the ninth bit goes to a status bit, and a word-ready flag is raised. If the interrupt is enabled, the flag drives an interrupt line.

The serial clock comes from outside, so the receiver needs no local timing. It keeps receiving while the rest of the chip is in a sleep state, and the interrupt for a finished word can serve as the wake-up request. Software reads the status register first, to get the ninth bit and any error, and then reads the data register. Reading the data register clears the word-ready flag. If a second word arrives before the first has been read, the block flags an overrun and keeps the older word. It then refuses further words until the continuous-receive enable is cleared and set again.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0x10 and the data register (address 2) reads 0x00.
- R2: The receiver accepts serial clock edges only when control bit 0 (port enable), bit 1 (synchronous mode) and bit 3 (continuous receive) are all 1 and bit 2 (clock-master select) is 0. In every other setting no word completes and status bit 3 stays 0.
- R3: With control bit 5 at 0, the line is sampled on each falling serial-clock edge, least significant bit first. After eight edges the word appears in the data register and status bit 3 (word ready) becomes 1.
- R4: With control bit 5 at 1, a word is nine bits. The first eight bits go to the data register and the ninth to status bit 0. In 8-bit mode status bit 0 reads 0.
- R5: A bus read of address 2 clears status bit 3.
- R6: The irq output is high exactly when status bit 3 is 1 and control bit 6 (interrupt enable) is 1.
- R7: If a word completes while status bit 3 is 1, status bit 1 (overrun) becomes 1 and the data register keeps the earlier word. While overrun is 1, no later word is accepted. Clearing control bit 3 clears overrun.
- R8: Control bit 4 (single-receive request) has no effect on reception.
- R9: Clearing control bit 3 discards any partly received word, so the next word after re-enabling starts with its first bit.
- R10: Status bit 2 (framing error) always reads 0 and status bit 4 (transmit shift empty) always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe (control register only) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 2 clears word ready |
| rd_data | output | 8 | Combinational read data for addr |
| sclk_in | input | 1 | Serial clock from the external master |
| sdata_in | input | 1 | Serial data line |
| irq | output | 1 | Receive interrupt / wake-up request |

## Verification
Read data is combinational, so the bench samples rd_data in the same cycle it drives addr, half a clock before the edge at which a data-register read clears the ready flag. After a falling serial-clock edge, two synchronizer stages and one edge register pass before the word registers load. The word is therefore visible on the third system clock edge after the fall. The bench waits eight system clocks after the last edge before reading any status, and it holds the data line steady across each serial edge for eight clocks on each side. The irq output is sampled together with the status read, since both come from the same flag register.

// File: rtl/sync_slave_rx.sv
module sync_slave_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       sclk_in,
  input  logic       sdata_in,
  output logic       irq
);

  logic [6:0] ctrl;
  logic [2:0] ck_sync;
  logic [1:0] dt_sync;
  logic [8:0] shreg;
  logic [3:0] cnt;
  logic [7:0] data_q;
  logic       b9_q, done_q, ovr_q;

  wire port_en = ctrl[0];
  wire sync_md = ctrl[1];
  wire ck_mst  = ctrl[2];
  wire rx_cont = ctrl[3];
  wire nine    = ctrl[5];
  wire int_en  = ctrl[6];

  wire       active   = port_en & sync_md & ~ck_mst & rx_cont;
  wire       fall     = ck_sync[2] & ~ck_sync[1];
  wire       take     = fall & active & ~ovr_q;
  wire [3:0] last_idx = nine ? 4'd8 : 4'd7;
  wire       word_end = take & (cnt == last_idx);
  wire [8:0] sh_nx    = {dt_sync[1], shreg[8:1]};
  wire       rd_data_reg = rd_en & (addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync <= 3'b111;
      dt_sync <= 2'b00;
    end else begin
      ck_sync <= {ck_sync[1:0], sclk_in};
      dt_sync <= {dt_sync[0], sdata_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_en && addr == 2'd0) ctrl <= wr_data[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!active) begin
      cnt   <= '0;
    end else if (take) begin
      shreg <= sh_nx;
      cnt   <= word_end ? 4'd0 : cnt + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      b9_q   <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_data_reg) done_q <= 1'b0;
      if (!rx_cont) ovr_q <= 1'b0;
      if (word_end) begin
        if (done_q) ovr_q <= 1'b1;
        else begin
          data_q <= nine ? sh_nx[7:0] : sh_nx[8:1];
          b9_q   <= nine & sh_nx[8];
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {1'b0, ctrl};
      2'd1:    rd_data = {3'b000, 1'b1, done_q, 1'b0, ovr_q, b9_q};
      2'd2:    rd_data = data_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign irq = done_q & int_en;

  a_r3_ready_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(word_end));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_reg && !word_end) |=> !done_q);

  a_r7_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> $stable(data_q));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_cont |=> (cnt == 4'd0 && !ovr_q));

endmodule

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic sclk_in = 1, sdata_in = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  sync_slave_rx uut (.*);

  always #5 clk = ~clk;

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic [7:0] exp_status(input logic b9, ovr, rdy);
    return {3'b000, 1'b1, rdy, 1'b0, ovr, b9};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send(input logic [8:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdata_in = w[i];
      repeat (8) @(negedge clk);
      sclk_in = 0;
      repeat (8) @(negedge clk);
      sclk_in = 1;
    end
    repeat (8) @(negedge clk);
  endtask

  localparam logic [7:0] EN = 8'h0B;
  logic [7:0] v;
  logic [8:0] w;
  bit nine_m, ie;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 ctrl reset", v, 8'h00);
    rd(1, v); chk("R1 status reset", v, 8'h10);
    rd(2, v); chk("R1 data reset", v, 8'h00);
    chk("R6 irq reset", irq, 0);

    wr(0, 8'h09); send(9'h0A5, 8);
    rd(1, v); chk("R2 no sync mode", v, exp_status(0, 0, 0));
    wr(0, 8'h0F); send(9'h0A5, 8);
    rd(1, v); chk("R2 clock master set", v, exp_status(0, 0, 0));
    wr(0, 8'h13); send(9'h0A5, 8);
    rd(1, v); chk("R8 single request alone", v, exp_status(0, 0, 0));

    wr(0, EN | 8'h10); send(9'h0C3, 8);
    rd(1, v); chk("R8 single request with cont", v, exp_status(0, 0, 1));
    chk("R6 irq off when disabled", irq, 0);
    rd(2, v); chk("R3 data 0xC3", v, 8'hC3);
    rd(1, v); chk("R5 read clears ready", v, exp_status(0, 0, 0));

    for (int k = 0; k < 24; k++) begin
      nine_m = 1'($urandom_range(0, 1));
      ie = 1'($urandom_range(0, 1));
      w = 9'($urandom_range(0, 511));
      wr(0, EN | (nine_m ? 8'h20 : 8'h00) | (ie ? 8'h40 : 8'h00));
      send(w, nine_m ? 9 : 8);
      chk("R6 irq with word", irq, int'(ie));
      rd(1, v);
      chk(nine_m ? "R4 status ninth bit" : "R3 status 8-bit", v,
          exp_status(nine_m & w[8], 0, 1));
      rd(2, v);
      chk(nine_m ? "R4 data low byte" : "R3 data byte", v, w[7:0]);
      chk("R5 irq cleared by read", irq, 0);
      rd(1, v); chk("R10 fixed bits", v & 8'h14, 8'h10);
    end

    wr(0, EN);
    send(9'h011, 8);
    send(9'h022, 8);
    rd(1, v); chk("R7 overrun set", v, exp_status(0, 1, 1));
    rd(2, v); chk("R7 old word kept", v, 8'h11);
    send(9'h033, 8);
    rd(1, v); chk("R7 locked while overrun", v, exp_status(0, 1, 0));
    wr(0, EN & ~8'h08);
    rd(1, v); chk("R7 overrun cleared", v, exp_status(0, 0, 0));
    wr(0, EN);
    send(9'h044, 8);
    rd(2, v); chk("R7 accepts after toggle", v, 8'h44);

    send(9'h007, 3);
    wr(0, EN & ~8'h08);
    wr(0, EN);
    send(9'h05A, 8);
    rd(1, v); chk("R9 ready after restart", v, exp_status(0, 0, 1));
    rd(2, v); chk("R9 partial word dropped", v, 8'h5A);

    wr(0, EN | 8'h20);
    send(9'h1FF, 9);
    rd(1, v); chk("R4 ninth bit one", v, exp_status(1, 0, 1));
    rd(2, v); chk("R4 byte all ones", v, 8'hFF);
    wr(0, EN);
    send(9'h100, 8);
    rd(1, v); chk("R4 ninth bit zero in 8-bit", v, exp_status(0, 0, 1));
    rd(0, v); chk("R1 ctrl readback", v, EN);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule